// File: doc/BRIEF.md
# Single-Port Register Bank with Read/Write Mode Select

This block keeps 32 general-purpose 32-bit registers behind one access port. Each clock cycle the port does exactly one thing. A single mode bit chooses between reading and writing, and a shared 5-bit index names the register that the operation touches. A datapath uses it as a compact register store when it never needs a read and a write in the same cycle.

A write stores the data input into the indexed register on the rising edge. A read copies the indexed register into an output register on the rising edge, so the result can be used from that edge until the next read. During a write cycle the output has no defined meaning. This implementation keeps the last read result on the output during writes. A synchronous, active-high reset clears every register and the output. Register 0 is an ordinary storage location.

Top module: `sp_regbank`

## Requirements
- R1: While `rst` is 1 at a rising edge, every register and `rd_data` become zero. After that, a read of any index returns 0.
- R2: When `op_read` is 0 (write) at a rising edge, `wr_data` is stored into the register selected by `idx`.
- R3: When `op_read` is 1 (read) at a rising edge, `rd_data` holds the contents of the register selected by `idx` after that edge.
- R4: In a read cycle `wr_data` has no effect: no register changes, whatever value `wr_data` carries.
- R5: In a write cycle `rd_data` keeps the value it had before the edge.
- R6: A write changes only the indexed register. All 31 other registers keep their contents.
- R7: A read in the cycle right after a write to the same index returns the newly written value.
- R8: Both boundary indices, 0 and 31, store and return arbitrary values. Register 0 is not tied to zero.
- R9: A read or write that follows a reset applied in mid-run sees only the zeroed state. No value written before that reset survives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_read | input | 1 | Operation select: 1 = read, 0 = write |
| idx | input | 5 | Index of the register used this cycle |
| wr_data | input | 32 | Value stored on a write cycle |
| rd_data | output | 32 | Registered read result |

## Verification
The bench first fills every index with a value derived from the index. Reading all of them back then separates wrong decoding from stuck or aliased storage, including at indices 0 and 31. Reads carry deliberately noisy `wr_data`, and the register is then read back, so a design that lets data through during a read stands out from a correct one. Write-then-read pairs on the same index, and long runs of back-to-back writes, show whether the read path is current and whether the output holds during writes. A long stretch of random operations and a reset in mid-run cover mixed orderings and the clearing of old contents.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int RB_WORD_W = 32;
    localparam int RB_DEPTH  = 32;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    function automatic op_e decode_op(input logic mode_bit);
        return mode_bit ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  regbank_pkg::op_e      op,
    input  logic [IDX_W-1:0]      idx,
    output logic [DEPTH-1:0]      wr_en,
    output logic                  rd_en
);
    import regbank_pkg::*;

    assign rd_en = (op == OP_READ);

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign wr_en[g] = (op == OP_WRITE) && (idx == IDX_W'(g));
    end

    // R6
    wr_en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    // R4
    no_write_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (wr_en == '0));

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DEPTH-1:0]               wr_en,
    input  logic [WORD_W-1:0]              wr_data,
    output logic [DEPTH-1:0][WORD_W-1:0]   regs_q
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_en[g]) begin
                regs_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/regbank_readout.sv
module regbank_readout #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_en,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DEPTH-1:0][WORD_W-1:0]   regs_q,
    output logic [WORD_W-1:0]              rd_data
);

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == IDX_W'(i)) sel_word = regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_word;
        end
    end

    // R1
    out_cleared_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R5
    out_hold_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/sp_regbank.sv
module sp_regbank #(
    parameter int WORD_W = regbank_pkg::RB_WORD_W,
    parameter int DEPTH  = regbank_pkg::RB_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_read,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    import regbank_pkg::*;

    op_e                          op;
    logic [DEPTH-1:0]             wr_en;
    logic                         rd_en;
    logic [DEPTH-1:0][WORD_W-1:0] regs_q;

    assign op = decode_op(op_read);

    regbank_decode #(.DEPTH(DEPTH)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .idx   (idx),
        .wr_en (wr_en),
        .rd_en (rd_en)
    );

    regbank_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    regbank_readout #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_readout (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .idx     (idx),
        .regs_q  (regs_q),
        .rd_data (rd_data)
    );

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        !op_read |=> (regs_q[$past(idx)] == $past(wr_data)));

    // R4
    read_keeps_store_chk: assert property (@(posedge clk) disable iff (rst)
        op_read |=> $stable(regs_q));

    // R3
    read_returns_entry_chk: assert property (@(posedge clk) disable iff (rst)
        op_read |=> (rd_data == $past(regs_q[idx])));

endmodule

// File: tb/sp_regbank_bench.sv
module sp_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_read = 1'b1;
    logic [4:0]  idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [31:0] model [NREG];
    logic [31:0] exp_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_regbank u_sp_regbank (
        .clk     (clk),
        .rst     (rst),
        .op_read (op_read),
        .idx     (idx),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_fails++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, got, want);
        end
    endtask

    // drive at a falling edge, let the rising edge act, compare at the next falling edge
    task automatic step(input logic rd, input int ix, input logic [31:0] d, input string tag);
        op_read = rd;
        idx     = 5'(ix);
        wr_data = d;
        @(negedge clk);
        if (rd) exp_out = model[ix];
        else    model[ix] = d;
        check(tag, rd_data, exp_out);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        exp_out = '0;
        check(tag, rd_data, exp_out);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        exp_out = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 output after reset", rd_data, 32'h0);

        // R1: every register reads zero after reset
        for (int i = 0; i < NREG; i++) step(1'b1, i, 32'hFFFF_FFFF, "R1 cleared entry");

        // R2, R6, R8, R5: fill with index-derived values; output must hold
        for (int i = 0; i < NREG; i++) step(1'b0, i, 32'hA5A5_0000 ^ (i * 32'h0101_0101), "R5 hold while writing");

        // R2, R3, R6, R8: read all back
        for (int i = NREG - 1; i >= 0; i--) step(1'b1, i, 32'h0, "R3 readback");

        // R4: reads with noisy data, then confirm contents
        for (int i = 0; i < NREG; i++) step(1'b1, i, ~(32'h1234_5678 + i), "R4 noisy read");
        for (int i = 0; i < NREG; i++) step(1'b1, i, 32'h0, "R4 contents unchanged");

        // R7, R8: write then read at once, boundaries included
        step(1'b0, 0, 32'hDEAD_BEEF, "R8 write idx0");
        step(1'b1, 0, 32'h0, "R7 read after write idx0");
        step(1'b0, 31, 32'hFFFF_FFFF, "R8 write idx31");
        step(1'b1, 31, 32'h0, "R7 read after write idx31");
        step(1'b0, 7, 32'h0000_0001, "R5 hold");
        step(1'b0, 7, 32'h8000_0000, "R2 overwrite");
        step(1'b1, 7, 32'h0, "R7 last write wins");
        step(1'b1, 6, 32'h0, "R6 neighbour low");
        step(1'b1, 8, 32'h0, "R6 neighbour high");

        // mixed random traffic
        for (int k = 0; k < 600; k++) begin
            logic rd;
            int   ix;
            rd = 1'($urandom_range(0, 1));
            ix = int'($urandom_range(0, NREG - 1));
            step(rd, ix, $urandom, rd ? "R3 random read" : "R5 random write");
        end

        // R9: mid-run reset wipes old contents
        do_reset("R9 output after mid-run reset");
        for (int i = 0; i < NREG; i++) step(1'b1, i, 32'h0, "R9 entry cleared");
        step(1'b0, 12, 32'h0BAD_F00D, "R9 write after reset");
        step(1'b1, 12, 32'h0, "R9 read after reset");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule